// File: doc/BRIEF.md
# System Control Register File with Cycle Timer

This block is the small bank of system control registers that sits next to a 32-bit RISC core. It holds a free-running cycle counter, a compare value, a processor status word and an interrupt cause word. All four are selected by a 5-bit register number. The core reads them through a combinational port, which serves a move-from instruction. It writes them through a clocked port, which serves a move-to instruction.

The counter and the compare value form a timer. When the counter reaches a nonzero compare value, a timer interrupt is raised. It stays high until software writes a new compare value. The cause word samples six external hardware interrupt lines on every cycle, and the timer interrupt is folded into the top line. Most of the cause word cannot be changed by software. A read that hits the register being written in the same cycle returns the value that register is about to take.

Top module: `sysctl_regs`

## Requirements
- R1: Count (register 9) increases by one on every clock edge that carries no write to it. It wraps from 0xFFFFFFFF to 0.
- R2: A write to Count overrides the increment. The written value is read back in the cycle after the write edge.
- R3: Compare (register 11) stores all 32 written bits and reads them back.
- R4: `timer_irq` rises on the edge after Count equals a nonzero Compare. It then stays high while Count moves on.
- R5: A write to Compare drives `timer_irq` low on that edge. A Compare of zero never raises `timer_irq`.
- R6: A register number other than 9, 11, 12 or 13 reads as zero. A write to such a number changes no register.
- R7: Status (register 12) resets to 0x10000000, which is the usable field bits 31:28 = 4'b0001. Only bits 31:27, 15:8 and 0 are writable, giving a write mask of 0xF800FF01. All other Status bits read zero.
- R8: In Cause (register 13), software can write only bits 23, 22, 9 and 8, giving a write mask of 0x00C00300. Writes to all other Cause bits are ignored.
- R9: Cause bits 15:10 take the value of `hw_irq[5:0]` on every edge. Bit 15 is also set while `timer_irq` is high. The result is visible one cycle later.
- R10: When the read number equals the write number and `wr_en` is high, `rd_data` returns the write data in the same cycle. For Status and Cause, the write mask is applied first. For an unmapped number, the value is zero.
- R11: A synchronous active-high `rst` clears Count, Compare, Cause and `timer_irq`, and sets Status to 0x10000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr | input | 5 | Register number for the combinational read |
| rd_data | output | 32 | Read data |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Register number for the write |
| wr_data | input | 32 | Write data |
| hw_irq | input | 6 | External hardware interrupt lines |
| timer_irq | output | 1 | Timer interrupt |

## Verification
The hardest state to reach is the timer match. With a reset counter, the match needs billions of cycles. The stimulus therefore first writes Compare, then loads Count a few steps below it, and follows the exact edge on which `timer_irq` rises. It then watches the interrupt hold and propagate into Cause bit 15, and finally clears it with a Compare write. The counter wrap is reached in the same way, by preloading Count near the top of its range.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   localparam int unsigned REG_AW = 5;
   localparam int unsigned REG_DW = 32;
   localparam logic [REG_AW-1:0] RN_COUNT   = 5'd9;
   localparam logic [REG_AW-1:0] RN_COMPARE = 5'd11;
   localparam logic [REG_AW-1:0] RN_STATUS  = 5'd12;
   localparam logic [REG_AW-1:0] RN_CAUSE   = 5'd13;
   localparam logic [REG_DW-1:0] STATUS_WMASK = 32'hF800_FF01;
   localparam logic [REG_DW-1:0] CAUSE_WMASK  = 32'h00C0_0300;
   localparam int unsigned CAUSE_HW_LSB = 10;
   localparam int unsigned STATUS_CU_LSB = 28;
endpackage

// File: rtl/sysctl_timer.sv
module sysctl_timer #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         cnt_we,
   input  logic         cmp_we,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] count_o,
   output logic [W-1:0] compare_o,
   output logic         irq_o
);
   logic [W-1:0] count_q, compare_q;
   logic         irq_q, past_ok;
   logic         match;

   generate
      if (W < 2) begin : g_bad_w
         $error("sysctl_timer: W must be at least 2");
      end
   endgenerate

   assign match = (count_q == compare_q) && (compare_q != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q   <= '0;
         compare_q <= '0;
         irq_q     <= 1'b0;
         past_ok   <= 1'b0;
      end else begin
         past_ok <= 1'b1;
         if (cnt_we) count_q <= wr_data;
         else        count_q <= count_q + 1'b1;
         if (cmp_we) begin
            compare_q <= wr_data;
            irq_q     <= 1'b0;
         end else if (match) begin
            irq_q <= 1'b1;
         end
      end
   end

   assign count_o   = count_q;
   assign compare_o = compare_q;
   assign irq_o     = irq_q;

   assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(cnt_we)) |-> (count_q == $past(count_q) + 1'b1));
   assert_count_load_R2: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(cnt_we)) |-> (count_q == $past(wr_data)));
   assert_irq_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(irq_q) && !$past(cmp_we)) |-> irq_q);
   assert_irq_rise_R4: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $rose(irq_q)) |-> $past(count_q == compare_q && compare_q != '0));
   assert_irq_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(cmp_we)) |-> !irq_q);
endmodule

// File: rtl/sysctl_status.sv
module sysctl_status #(
   parameter int unsigned   W      = 32,
   parameter logic [W-1:0]  WMASK  = 32'hF800_FF01,
   parameter int unsigned   CU_LSB = 28,
   parameter logic [3:0]    CU_RST = 4'b0001
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         we,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] status_o
);
   localparam logic [W-1:0] RST_VAL = W'(CU_RST) << CU_LSB;
   logic [W-1:0] status_q;
   logic         past_ok;

   generate
      if (CU_LSB + 4 > W) begin : g_bad_cu
         $error("sysctl_status: usable field outside word");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         status_q <= RST_VAL;
         past_ok  <= 1'b0;
      end else begin
         past_ok <= 1'b1;
         if (we) status_q <= wr_data & WMASK;
      end
   end

   assign status_o = status_q;

   assert_status_keep_R7: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(we)) |-> $stable(status_q));
   assert_status_load_R7: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(we)) |-> (status_q == ($past(wr_data) & WMASK)));
endmodule

// File: rtl/sysctl_cause.sv
module sysctl_cause #(
   parameter int unsigned  W      = 32,
   parameter int unsigned  HW_W   = 6,
   parameter int unsigned  HW_LSB = 10,
   parameter logic [W-1:0] WMASK  = 32'h00C0_0300
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            we,
   input  logic [W-1:0]    wr_data,
   input  logic [HW_W-1:0] hw_irq,
   input  logic            timer_irq,
   output logic [W-1:0]    cause_o
);
   localparam int unsigned TOP_BIT = HW_LSB + HW_W - 1;
   logic [W-1:0] cause_q, cause_d;
   logic         past_ok;

   generate
      if (TOP_BIT >= W) begin : g_bad_hw
         $error("sysctl_cause: hardware lines outside word");
      end
   endgenerate

   always_comb begin
      cause_d = cause_q;
      if (we) cause_d = (cause_q & ~WMASK) | (wr_data & WMASK);
      cause_d[HW_LSB +: HW_W] = hw_irq;
      cause_d[TOP_BIT] = hw_irq[HW_W-1] | timer_irq;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cause_q <= '0;
         past_ok <= 1'b0;
      end else begin
         past_ok <= 1'b1;
         cause_q <= cause_d;
      end
   end

   assign cause_o = cause_q;

   assert_cause_hw_R9: assert property (@(posedge clk) disable iff (rst)
      past_ok |-> (cause_q[TOP_BIT-1:HW_LSB] == $past(hw_irq[HW_W-2:0])));
   assert_cause_timer_R9: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(timer_irq)) |-> cause_q[TOP_BIT]);
   assert_cause_ro_R8: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(we)) |-> ((cause_q & WMASK) == $past(cause_q & WMASK)));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
   import sysctl_pkg::*;
#(
   parameter int unsigned DW         = 32,
   parameter int unsigned HW_W       = 6,
   parameter bit          FORWARD_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [4:0]      rd_addr,
   output logic [DW-1:0]   rd_data,
   input  logic            wr_en,
   input  logic [4:0]      wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic [HW_W-1:0] hw_irq,
   output logic            timer_irq
);
   logic [DW-1:0] count_w, compare_w, status_w, cause_w;
   logic [DW-1:0] stored_rd, fwd_val;
   logic          cnt_we, cmp_we, st_we, ca_we;

   generate
      if (DW != REG_DW) begin : g_bad_dw
         $error("sysctl_regs: DW must match the register width");
      end
   endgenerate

   assign cnt_we = wr_en && (wr_addr == RN_COUNT);
   assign cmp_we = wr_en && (wr_addr == RN_COMPARE);
   assign st_we  = wr_en && (wr_addr == RN_STATUS);
   assign ca_we  = wr_en && (wr_addr == RN_CAUSE);

   sysctl_timer #(.W(DW)) u_timer (
      .clk(clk), .rst(rst), .cnt_we(cnt_we), .cmp_we(cmp_we),
      .wr_data(wr_data), .count_o(count_w), .compare_o(compare_w),
      .irq_o(timer_irq)
   );

   sysctl_status #(.W(DW), .WMASK(STATUS_WMASK), .CU_LSB(STATUS_CU_LSB),
                   .CU_RST(4'b0001)) u_status (
      .clk(clk), .rst(rst), .we(st_we), .wr_data(wr_data), .status_o(status_w)
   );

   sysctl_cause #(.W(DW), .HW_W(HW_W), .HW_LSB(CAUSE_HW_LSB),
                  .WMASK(CAUSE_WMASK)) u_cause (
      .clk(clk), .rst(rst), .we(ca_we), .wr_data(wr_data), .hw_irq(hw_irq),
      .timer_irq(timer_irq), .cause_o(cause_w)
   );

   always_comb begin
      case (rd_addr)
         RN_COUNT:   stored_rd = count_w;
         RN_COMPARE: stored_rd = compare_w;
         RN_STATUS:  stored_rd = status_w;
         RN_CAUSE:   stored_rd = cause_w;
         default:    stored_rd = '0;
      endcase
   end

   always_comb begin
      case (wr_addr)
         RN_COUNT:   fwd_val = wr_data;
         RN_COMPARE: fwd_val = wr_data;
         RN_STATUS:  fwd_val = wr_data & STATUS_WMASK;
         RN_CAUSE:   fwd_val = (cause_w & ~CAUSE_WMASK) | (wr_data & CAUSE_WMASK);
         default:    fwd_val = '0;
      endcase
   end

   generate
      if (FORWARD_EN) begin : g_fwd
         assign rd_data = (wr_en && (wr_addr == rd_addr)) ? fwd_val : stored_rd;
      end else begin : g_nofwd
         assign rd_data = stored_rd;
      end
   endgenerate

   assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (rd_addr != RN_COUNT && rd_addr != RN_COMPARE && rd_addr != RN_STATUS &&
       rd_addr != RN_CAUSE) |-> (rd_data == '0));
endmodule

// File: tb/test_sysctl_regs.sv
module test_sysctl_regs;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [5:0]  hw_irq = '0;
   logic        timer_irq;
   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   sysctl_regs i_sysctl_regs (
      .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .hw_irq(hw_irq), .timer_irq(timer_irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] v);
      rd_addr = a;
      #1 v = rd_data;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(5'd9, v);  chk("R11 count", v, 32'h0);
      rd(5'd11, v); chk("R11 compare", v, 32'h0);
      rd(5'd12, v); chk("R11/R7 status", v, 32'h1000_0000);
      rd(5'd13, v); chk("R11 cause", v, 32'h0);
      chk("R11 timer_irq", {31'b0, timer_irq}, 32'h0);
   endtask

   task automatic t_count;
      logic [31:0] a, b;
      @(negedge clk); rd(5'd9, a);
      @(negedge clk); rd(5'd9, b);
      chk("R1 step", b, a + 32'd1);
      wr(5'd9, 32'hFFFF_FFFE);
      rd(5'd9, a); chk("R2 load", a, 32'hFFFF_FFFE);
      @(negedge clk); rd(5'd9, a); chk("R1 top", a, 32'hFFFF_FFFF);
      @(negedge clk); rd(5'd9, a); chk("R1 wrap", a, 32'h0);
   endtask

   task automatic t_compare_rw;
      logic [31:0] v;
      wr(5'd11, 32'hDEAD_BEEF);
      rd(5'd11, v); chk("R3 compare", v, 32'hDEAD_BEEF);
   endtask

   task automatic t_timer;
      logic [31:0] v;
      wr(5'd11, 32'h100);
      wr(5'd9, 32'hFD);
      @(negedge clk); @(negedge clk); @(negedge clk);
      chk("R4 no early irq", {31'b0, timer_irq}, 32'h0);
      @(negedge clk);
      chk("R4 irq rises", {31'b0, timer_irq}, 32'h1);
      @(negedge clk);
      chk("R4 irq held", {31'b0, timer_irq}, 32'h1);
      rd(5'd13, v); chk("R9 timer in cause", v & 32'h8000, 32'h8000);
      wr(5'd11, 32'h8000_0000);
      chk("R5 compare write clears", {31'b0, timer_irq}, 32'h0);
      wr(5'd11, 32'h0);
      wr(5'd9, 32'hFFFF_FFFE);
      repeat (4) @(negedge clk);
      chk("R5 zero compare", {31'b0, timer_irq}, 32'h0);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      wr(5'd11, 32'h5555_AAAA);
      wr(5'd10, 32'hFFFF_FFFF);
      rd(5'd10, v); chk("R6 unmapped read", v, 32'h0);
      rd(5'd11, v); chk("R6 compare untouched", v, 32'h5555_AAAA);
      rd(5'd0, v);  chk("R6 reg0 zero", v, 32'h0);
   endtask

   task automatic t_status;
      logic [31:0] v;
      wr(5'd12, 32'hFFFF_FFFF);
      rd(5'd12, v); chk("R7 mask", v, 32'hF800_FF01);
      wr(5'd12, 32'h0);
      rd(5'd12, v); chk("R7 clear", v, 32'h0);
   endtask

   task automatic t_cause;
      logic [31:0] v;
      hw_irq = 6'h0;
      wr(5'd13, 32'hFFFF_FFFF);
      rd(5'd13, v); chk("R8 mask", v, 32'h00C0_0300);
      wr(5'd13, 32'h0);
      rd(5'd13, v); chk("R8 clear", v, 32'h0);
      hw_irq = 6'h2A;
      @(negedge clk);
      rd(5'd13, v); chk("R9 hw lines", v, 32'h0000_A800);
      hw_irq = 6'h0;
      @(negedge clk);
      rd(5'd13, v); chk("R9 hw drop", v, 32'h0);
   endtask

   task automatic t_forward;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'd11; wr_data = 32'h1234_5678; rd_addr = 5'd11;
      #1 chk("R10 compare fwd", rd_data, 32'h1234_5678);
      wr_addr = 5'd12; wr_data = 32'hFFFF_FFFF; rd_addr = 5'd12;
      #1 chk("R10 status fwd", rd_data, 32'hF800_FF01);
      wr_addr = 5'd13; rd_addr = 5'd13;
      #1 chk("R10 cause fwd", rd_data, 32'h00C0_0300);
      wr_addr = 5'd14; rd_addr = 5'd14;
      #1 chk("R10 unmapped fwd", rd_data, 32'h0);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset_again;
      wr(5'd9, 32'h77);
      wr(5'd11, 32'h99);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk); rst = 1'b0;
      t_reset();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_count();
      t_compare_rw();
      t_timer();
      t_unmapped();
      t_status();
      t_cause();
      t_forward();
      t_reset_again();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #4_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule